// File: doc/BRIEF.md
# Programmed I/O Disk Controller Interface

This block sits between a 12-bit accumulator processor and a floppy disk controller. The processor issues I/O strobes with a device code and a 3-bit operation code. The block decodes them into seven operations: load command, transfer data, three skip tests, interrupt enable/disable, and initialize. A single 12-bit interface register carries commands, addresses and data to and from the drive. Three sticky flags record events from the drive side: transfer request, error and done. The processor polls these flags with skip operations or takes an interrupt on done.

On the drive side the block gives a one-cycle run strobe, the interface register contents and the selected word-length mode. It takes a direction level, a return data bus and three event lines. A maintenance loopback mode lets software write and read back the interface register without starting the drive. It also forces the skip flags set, so the skip and interrupt paths can be tested.

All processor-facing results (skip, accumulator load and value, run) are registered. They are valid for exactly one clock cycle, in the cycle after the strobe.

Top module: `pio_disk_port`

## Requirements
- R1: An operation takes effect only when `io_strobe` is high and `io_dev` equals `DEV_CODE`. A strobe with any other device code produces no skip, no accumulator load and no run, and leaves all flags unchanged.
- R2: Load command (opcode 1) is accepted when `drv_done` is high or maintenance is set. When accepted, it copies `ac_in` into the interface register and loads zero into the accumulator. Bit numbering runs from 0 (MSB, `ac_in[11]`) to 11 (LSB). Bit 4 (`ac_in[7]`) sets or clears maintenance. Bit 5 (`ac_in[6]`) picks 8-bit mode when 1. Run pulses unless the new maintenance bit is 1.
- R3: A load command issued while `drv_done` is low and maintenance is clear is ignored. It gives no run and no accumulator load, and leaves the interface register unchanged.
- R4: Transfer data (opcode 2) with `drv_dir` = 0 and maintenance clear does three things. It copies all 12 bits of `ac_in` into the interface register, in either mode. It pulses run. It does not load the accumulator.
- R5: Transfer data with `drv_dir` = 1 in 12-bit mode, maintenance clear, loads `drv_rdata` unchanged into the accumulator. It also pulses run.
- R6: In 8-bit mode, a transfer into the accumulator works on the low byte only. The accumulator receives `ac_in[11:8]` unchanged in its top four bits, and `ac_in[7:0] | data[7:0]` in its low eight bits.
- R7: Opcodes 3, 4 and 5 test the transfer-request, error and done flags respectively. Each asserts skip when its flag is set, then clears that flag, so an immediate repeat does not skip.
- R8: A rising edge on `drv_tr`, `drv_err` or `drv_done` sets the matching flag. A rising edge on `drv_err` also sets the done flag. A level held high after its flag is cleared does not set the flag again.
- R9: Opcode 6 sets interrupt enable when `ac_in[0]` is 1 and clears it when `ac_in[0]` is 0. `irq` is high while both the done flag and interrupt enable are set.
- R10: While maintenance is set, transfer data never pulses run. It always loads the interface register into the accumulator, merged according to R6 in 8-bit mode. All three flags are held set, and skips do not clear them.
- R11: After maintenance is cleared, the three flags stay set until each is cleared by its own skip.
- R12: Initialize (opcode 7, or `rst_n` low) clears all flags, interrupt enable and maintenance, and returns to 12-bit mode.
- R13: Opcode 0 changes nothing: no skip, no accumulator load, no run, and no change to the interface register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus initialize |
| io_strobe | input | 1 | Single-cycle I/O operation strobe |
| io_dev | input | DEV_W | Device code of the operation |
| io_op | input | 3 | Operation code |
| ac_in | input | WORD_W | Accumulator value from the processor |
| skip | output | 1 | Skip the next instruction (one cycle) |
| ac_load | output | 1 | Load `ac_out` into the accumulator (one cycle) |
| ac_out | output | WORD_W | New accumulator value |
| irq | output | 1 | Interrupt request |
| run | output | 1 | One-cycle start/continue strobe to the drive |
| drv_dir | input | 1 | 1 = drive supplies data, 0 = drive takes data |
| drv_wdata | output | WORD_W | Interface register contents |
| drv_rdata | input | WORD_W | Data word from the drive |
| drv_byte_mode | output | 1 | 1 = 8-bit mode selected |
| drv_tr | input | 1 | Drive transfer-request line |
| drv_err | input | 1 | Drive error line |
| drv_done | input | 1 | Drive done/idle line |

## Verification
The assertions assume that `io_strobe` is a single-cycle pulse carrying one operation. They also assume that the drive-side lines and `ac_in` are stable in the cycle the strobe is sampled. The one-cycle relations between a strobe and the registered skip, load and run outputs depend on this. The directed stimulus drives every input on the falling clock edge. Each strobe is separated by at least one idle cycle, and each drive event is a clean level change away from strobes. This keeps flag setting and flag clearing in distinct cycles, except where a held level is the point of the test.

// File: rtl/pio_disk_pkg.sv
package pio_disk_pkg;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_LCMD = 3'd1,
      OP_XFER = 3'd2,
      OP_SKTR = 3'd3,
      OP_SKER = 3'd4,
      OP_SKDN = 3'd5,
      OP_IEN  = 3'd6,
      OP_INIT = 3'd7
   } pio_op_e;

   typedef struct packed {
      logic lcmd;
      logic xfer;
      logic sk_tr;
      logic sk_er;
      logic sk_dn;
      logic ien;
      logic init;
   } pio_cmd_t;

   localparam int NUM_FLAGS = 3;
   localparam int FLG_TR    = 0;
   localparam int FLG_ER    = 1;
   localparam int FLG_DN    = 2;

endpackage

// File: rtl/pio_op_decode.sv
module pio_op_decode
   import pio_disk_pkg::*;
#(
   parameter int               DEV_W    = 6,
   parameter logic [DEV_W-1:0] DEV_CODE = 6'o75
) (
   input  logic             io_strobe,
   input  logic [DEV_W-1:0] io_dev,
   input  logic [2:0]       io_op,
   output pio_cmd_t         cmd
);

   logic hit;
   assign hit = io_strobe && (io_dev == DEV_CODE);

   always_comb begin
      cmd = '0;
      if (hit) begin
         case (pio_op_e'(io_op))
            OP_LCMD: cmd.lcmd  = 1'b1;
            OP_XFER: cmd.xfer  = 1'b1;
            OP_SKTR: cmd.sk_tr = 1'b1;
            OP_SKER: cmd.sk_er = 1'b1;
            OP_SKDN: cmd.sk_dn = 1'b1;
            OP_IEN:  cmd.ien   = 1'b1;
            OP_INIT: cmd.init  = 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pio_flag_bank.sv
module pio_flag_bank
   import pio_disk_pkg::*;
#(
   parameter int NF           = NUM_FLAGS,
   parameter bit EDGE_CAPTURE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          maint,
   input  logic [NF-1:0] raw_in,
   input  logic [NF-1:0] clr,
   output logic [NF-1:0] flag
);

   logic [NF-1:0] ev;
   logic [NF-1:0] set_v;

   generate
      if (NF != NUM_FLAGS) begin : g_bad_nf
         $error("pio_flag_bank: NF must equal NUM_FLAGS");
      end
      if (EDGE_CAPTURE) begin : g_edge
         logic [NF-1:0] prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= '1;
            else        prev <= raw_in;
         end
         assign ev = raw_in & ~prev;
      end else begin : g_level
         assign ev = raw_in;
      end
   endgenerate

   always_comb begin
      set_v         = ev;
      set_v[FLG_DN] = ev[FLG_DN] | ev[FLG_ER];
   end

   generate
      for (genvar i = 0; i < NF; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag[i] <= 1'b0;
            else if (init)     flag[i] <= 1'b0;
            else if (maint)    flag[i] <= 1'b1;
            else if (set_v[i]) flag[i] <= 1'b1;
            else if (clr[i])   flag[i] <= 1'b0;
         end

         p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (set_v[i] && !init) |=> flag[i])
            else $error("flag %0d not set by event", i);
      end
   endgenerate

   p_init_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (flag == '0))
      else $error("initialize left a flag set");

   p_maint_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(maint) && maint && !init) |=> (flag == '1))
      else $error("flags not held set in maintenance");

endmodule

// File: rtl/pio_data_path.sv
module pio_data_path #(
   parameter int WORD_W = 12,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_lcmd,
   input  logic              do_xfer,
   input  logic              do_init,
   input  logic [WORD_W-1:0] ac_in,
   input  logic              drv_done,
   input  logic              drv_dir,
   input  logic [WORD_W-1:0] drv_rdata,
   output logic [WORD_W-1:0] ireg,
   output logic [WORD_W-1:0] ac_out,
   output logic              ac_load,
   output logic              run,
   output logic              maint,
   output logic              mode8
);

   localparam int MAINT_BIT = WORD_W - 1 - 4;
   localparam int MODE_BIT  = WORD_W - 1 - 5;

   logic lcmd_ok;
   assign lcmd_ok = do_lcmd && (drv_done || maint);

   function automatic logic [WORD_W-1:0] merge_in(input logic              m8,
                                                  input logic [WORD_W-1:0] acc,
                                                  input logic [WORD_W-1:0] src);
      if (m8) return {acc[WORD_W-1:BYTE_W], acc[BYTE_W-1:0] | src[BYTE_W-1:0]};
      return src;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ireg    <= '0;
         ac_out  <= '0;
         ac_load <= 1'b0;
         run     <= 1'b0;
         maint   <= 1'b0;
         mode8   <= 1'b0;
      end else begin
         ac_load <= 1'b0;
         run     <= 1'b0;
         if (do_init) begin
            maint <= 1'b0;
            mode8 <= 1'b0;
         end else if (lcmd_ok) begin
            ireg    <= ac_in;
            ac_out  <= '0;
            ac_load <= 1'b1;
            maint   <= ac_in[MAINT_BIT];
            mode8   <= ac_in[MODE_BIT];
            run     <= ~ac_in[MAINT_BIT];
         end else if (do_xfer) begin
            if (maint) begin
               ac_out  <= merge_in(mode8, ac_in, ireg);
               ac_load <= 1'b1;
            end else if (drv_dir) begin
               ireg    <= drv_rdata;
               ac_out  <= merge_in(mode8, ac_in, drv_rdata);
               ac_load <= 1'b1;
               run     <= 1'b1;
            end else begin
               ireg <= ac_in;
               run  <= 1'b1;
            end
         end
      end
   end

   p_lcmd_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (do_lcmd && !drv_done && !maint) |=> (!run && !ac_load && $stable(ireg)))
      else $error("load command accepted while drive busy");

   p_lcmd_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (do_lcmd && !do_init && (drv_done || maint)) |=> (ac_load && ac_out == '0))
      else $error("accepted load command did not clear accumulator");

   p_maint_norun_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (do_xfer && maint) |=> !run)
      else $error("run pulsed in maintenance transfer");

endmodule

// File: rtl/pio_disk_port.sv
module pio_disk_port
   import pio_disk_pkg::*;
#(
   parameter int               WORD_W       = 12,
   parameter int               BYTE_W       = 8,
   parameter int               DEV_W        = 6,
   parameter logic [DEV_W-1:0] DEV_CODE     = 6'o75,
   parameter bit               EDGE_CAPTURE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_strobe,
   input  logic [DEV_W-1:0]  io_dev,
   input  logic [2:0]        io_op,
   input  logic [WORD_W-1:0] ac_in,
   output logic              skip,
   output logic              ac_load,
   output logic [WORD_W-1:0] ac_out,
   output logic              irq,
   output logic              run,
   input  logic              drv_dir,
   output logic [WORD_W-1:0] drv_wdata,
   input  logic [WORD_W-1:0] drv_rdata,
   output logic              drv_byte_mode,
   input  logic              drv_tr,
   input  logic              drv_err,
   input  logic              drv_done
);

   generate
      if (WORD_W < 12 || BYTE_W >= WORD_W || BYTE_W < 1) begin : g_bad_width
         $error("pio_disk_port: need WORD_W >= 12 and 1 <= BYTE_W < WORD_W");
      end
   endgenerate

   pio_cmd_t             cmd;
   logic [NUM_FLAGS-1:0] flag;
   logic [NUM_FLAGS-1:0] clr;
   logic [NUM_FLAGS-1:0] raw;
   logic                 maint;
   logic                 ien;

   pio_op_decode #(.DEV_W(DEV_W), .DEV_CODE(DEV_CODE)) u_dec (
      .io_strobe (io_strobe),
      .io_dev    (io_dev),
      .io_op     (io_op),
      .cmd       (cmd)
   );

   always_comb begin
      raw         = '0;
      raw[FLG_TR] = drv_tr;
      raw[FLG_ER] = drv_err;
      raw[FLG_DN] = drv_done;
      clr         = '0;
      clr[FLG_TR] = cmd.sk_tr;
      clr[FLG_ER] = cmd.sk_er;
      clr[FLG_DN] = cmd.sk_dn;
   end

   pio_flag_bank #(.NF(NUM_FLAGS), .EDGE_CAPTURE(EDGE_CAPTURE)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (cmd.init),
      .maint  (maint),
      .raw_in (raw),
      .clr    (clr),
      .flag   (flag)
   );

   pio_data_path #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .do_lcmd   (cmd.lcmd),
      .do_xfer   (cmd.xfer),
      .do_init   (cmd.init),
      .ac_in     (ac_in),
      .drv_done  (drv_done),
      .drv_dir   (drv_dir),
      .drv_rdata (drv_rdata),
      .ireg      (drv_wdata),
      .ac_out    (ac_out),
      .ac_load   (ac_load),
      .run       (run),
      .maint     (maint),
      .mode8     (drv_byte_mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skip <= 1'b0;
         ien  <= 1'b0;
      end else begin
         skip <= (cmd.sk_tr & flag[FLG_TR]) |
                 (cmd.sk_er & flag[FLG_ER]) |
                 (cmd.sk_dn & flag[FLG_DN]);
         if (cmd.init)     ien <= 1'b0;
         else if (cmd.ien) ien <= ac_in[0];
      end
   end

   assign irq = flag[FLG_DN] & ien;

   p_nodev_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_strobe && io_dev != DEV_CODE) |=> (!skip && !ac_load && !run))
      else $error("foreign device strobe had an effect");

   p_decode_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd.lcmd, cmd.xfer, cmd.sk_tr, cmd.sk_er, cmd.sk_dn, cmd.ien, cmd.init}))
      else $error("more than one operation decoded");

   p_skip_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      skip |-> $past(|flag))
      else $error("skip without any flag set");

   p_ien_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.ien && ac_in[0]) |=> (ien && (irq == flag[FLG_DN])))
      else $error("interrupt enable not set");

endmodule

// File: tb/tb_pio_disk_port.sv
`timescale 1ns/1ps
module tb_pio_disk_port;

   localparam int         W    = 12;
   localparam logic [5:0] DEV  = 6'o75;
   localparam real        TCLK = 20.0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         io_strobe = 1'b0;
   logic [5:0]   io_dev = '0;
   logic [2:0]   io_op = '0;
   logic [W-1:0] ac_in = '0;
   logic         skip, ac_load, irq, run, drv_byte_mode;
   logic [W-1:0] ac_out, drv_wdata;
   logic         drv_dir = 1'b0;
   logic [W-1:0] drv_rdata = '0;
   logic         drv_tr = 1'b0, drv_err = 1'b0, drv_done = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done_all = 1'b0;

   logic         r_skip, r_load, r_run;
   logic [W-1:0] r_ac;

   always #(TCLK/2) clk = ~clk;

   pio_disk_port dut (
      .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_dev(io_dev),
      .io_op(io_op), .ac_in(ac_in), .skip(skip), .ac_load(ac_load),
      .ac_out(ac_out), .irq(irq), .run(run), .drv_dir(drv_dir),
      .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
      .drv_byte_mode(drv_byte_mode), .drv_tr(drv_tr), .drv_err(drv_err),
      .drv_done(drv_done)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0o expected=%0o", req, act, exp);
      end
   endtask

   task automatic iot(input logic [2:0] op, input logic [W-1:0] ac, input logic [5:0] dev = DEV);
      @(negedge clk);
      io_strobe = 1'b1; io_op = op; ac_in = ac; io_dev = dev;
      @(negedge clk);
      io_strobe = 1'b0;
      r_skip = skip; r_load = ac_load; r_run = run; r_ac = ac_out;
      @(negedge clk);
   endtask

   task automatic pulse_tr();
      @(negedge clk) drv_tr = 1'b1;
      @(negedge clk) drv_tr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R12 reset skip", W'(skip), 0);
      chk("R12 reset ac_load", W'(ac_load), 0);
      chk("R12 reset run", W'(run), 0);
      chk("R12 reset irq", W'(irq), 0);
      chk("R12 reset mode", W'(drv_byte_mode), 0);
      chk("R12 reset ireg", drv_wdata, 0);
   endtask

   task automatic t_lcmd();
      drv_done = 1'b0;
      iot(3'd1, 12'o1234);
      chk("R3 busy lcmd run", W'(r_run), 0);
      chk("R3 busy lcmd load", W'(r_load), 0);
      chk("R3 busy lcmd ireg", drv_wdata, 0);
      @(negedge clk) drv_done = 1'b1;
      iot(3'd1, 12'o0012);
      chk("R2 lcmd run", W'(r_run), 1);
      chk("R2 lcmd load", W'(r_load), 1);
      chk("R2 lcmd ac clear", r_ac, 0);
      chk("R2 lcmd ireg", drv_wdata, 12'o0012);
      chk("R2 lcmd mode12", W'(drv_byte_mode), 0);
   endtask

   task automatic t_xfer();
      drv_dir = 1'b0;
      iot(3'd2, 12'o7777);
      chk("R4 write ireg", drv_wdata, 12'o7777);
      chk("R4 write run", W'(r_run), 1);
      chk("R4 write no load", W'(r_load), 0);
      drv_dir = 1'b1; drv_rdata = 12'o5252;
      iot(3'd2, 12'o1111);
      chk("R5 read12 ac", r_ac, 12'o5252);
      chk("R5 read12 load", W'(r_load), 1);
      chk("R5 read12 run", W'(r_run), 1);
      iot(3'd1, 12'o0100);
      chk("R2 lcmd mode8", W'(drv_byte_mode), 1);
      drv_rdata = 12'o7003;
      iot(3'd2, 12'o6250);
      chk("R6 read8 merge", r_ac, 12'o6253);
      drv_dir = 1'b0;
      iot(3'd2, 12'o7777);
      chk("R4 write8 all bits", drv_wdata, 12'o7777);
   endtask

   task automatic t_skips();
      iot(3'd5, 0);
      chk("R7 skip done set", W'(r_skip), 1);
      iot(3'd5, 0);
      chk("R8 held done not reset", W'(r_skip), 0);
      iot(3'd4, 0);
      chk("R7 no error skip", W'(r_skip), 0);
      pulse_tr();
      iot(3'd3, 0);
      chk("R7 skip tr", W'(r_skip), 1);
      iot(3'd3, 0);
      chk("R7 tr cleared", W'(r_skip), 0);
      @(negedge clk) drv_err = 1'b1;
      @(negedge clk) drv_err = 1'b0;
      iot(3'd4, 0);
      chk("R8 error flag", W'(r_skip), 1);
      iot(3'd5, 0);
      chk("R8 error sets done", W'(r_skip), 1);
   endtask

   task automatic t_irq();
      @(negedge clk) drv_done = 1'b0;
      @(negedge clk) drv_done = 1'b1;
      @(negedge clk);
      chk("R9 irq off without enable", W'(irq), 0);
      iot(3'd6, 12'o0001);
      chk("R9 irq on", W'(irq), 1);
      iot(3'd6, 12'o7776);
      chk("R9 irq disabled", W'(irq), 0);
      iot(3'd6, 12'o0001);
      iot(3'd5, 0);
      chk("R9 irq drops after done skip", W'(irq), 0);
      iot(3'd6, 12'o0000);
   endtask

   task automatic t_dev_nop();
      pulse_tr();
      iot(3'd3, 0, 6'o12);
      chk("R1 foreign skip", W'(r_skip), 0);
      iot(3'd3, 0);
      chk("R1 flag kept", W'(r_skip), 1);
      iot(3'd0, 12'o4321);
      chk("R13 nop run", W'(r_run), 0);
      chk("R13 nop load", W'(r_load), 0);
      chk("R13 nop ireg", drv_wdata, 12'o7777);
   endtask

   task automatic t_maint();
      iot(3'd1, 12'o0200);
      chk("R10 maint lcmd no run", W'(r_run), 0);
      chk("R10 maint lcmd load", W'(r_load), 1);
      @(negedge clk) drv_done = 1'b0;
      iot(3'd1, 12'o0234);
      chk("R10 maint lcmd ireg", drv_wdata, 12'o0234);
      drv_dir = 1'b0;
      iot(3'd2, 12'o7777);
      chk("R10 loopback ac", r_ac, 12'o0234);
      chk("R10 loopback load", W'(r_load), 1);
      chk("R10 loopback no run", W'(r_run), 0);
      chk("R10 ireg kept", drv_wdata, 12'o0234);
      iot(3'd3, 0);
      chk("R10 tr forced", W'(r_skip), 1);
      iot(3'd3, 0);
      chk("R10 tr not cleared", W'(r_skip), 1);
      iot(3'd4, 0);
      chk("R10 err forced", W'(r_skip), 1);
      iot(3'd5, 0);
      chk("R10 done forced", W'(r_skip), 1);
      iot(3'd1, 12'o0000);
      chk("R10 exit lcmd run", W'(r_run), 1);
      iot(3'd3, 0);
      chk("R11 tr still set", W'(r_skip), 1);
      iot(3'd3, 0);
      chk("R11 tr cleared", W'(r_skip), 0);
      iot(3'd4, 0);
      chk("R11 err still set", W'(r_skip), 1);
   endtask

   task automatic t_init();
      @(negedge clk) drv_done = 1'b1;
      @(negedge clk);
      iot(3'd6, 12'o0001);
      iot(3'd1, 12'o0100);
      chk("R12 pre mode8", W'(drv_byte_mode), 1);
      chk("R12 pre irq", W'(irq), 1);
      iot(3'd7, 0);
      chk("R12 init mode", W'(drv_byte_mode), 0);
      chk("R12 init irq", W'(irq), 0);
      iot(3'd5, 0);
      chk("R12 init done clear", W'(r_skip), 0);
      iot(3'd6, 12'o0001);
      chk("R12 init cleared enable", W'(irq), 0);
      pulse_tr();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      iot(3'd3, 0);
      chk("R12 bus reset tr clear", W'(r_skip), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lcmd();
      t_xfer();
      t_skips();
      t_irq();
      t_dev_nop();
      t_maint();
      t_init();
      if (!done_all) begin
         done_all = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_all) begin
         done_all = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule